// File: doc/BRIEF.md
# Cascaded Biquad Compensation Filter

This block sharpens the response of a measuring transducer in real time. It takes the 16-bit signed sample stream from an analog-to-digital converter and applies an IIR response meant to approximate the inverse of the sensor's own frequency response. It then hands one saturated 16-bit word per sample to a digital-to-analog converter. The response is a chain of up to five second-order sections. At run time, software picks how many of them take part in each pass.

Samples arrive at a low rate: 200 kHz against a 40 MHz processing clock, which leaves 200 clock cycles per sample. The block therefore shares one 32x48-bit multiplier across every product of every section. It spends five multiply cycles per section in a transposed direct-form II schedule. Coefficients are signed fixed-point values with 12 integer bits and 20 fraction bits. This gives gains in the thousands and feedback terms resolved to about one millionth. Coefficients are written through a small register port, but only while no pass is running. A synchronous clear empties the filter memory. A sticky flag records any output that hit the 16-bit limits.

Top module: `iir_comp_filter`

## Requirements
- R1: After reset, `out_sample` is 0 and `out_valid`, `busy` and `ovf_flag` are low. Every section then holds b0 = 1.0 with all other coefficients 0, so the output equals the input.
- R2: A coefficient write is accepted when `cfg_we` is high and `busy` is low. It stores `cfg_wdata` as a signed value with 20 fraction bits. `cfg_addr[5:3]` selects the section. `cfg_addr[2:0]` selects the term: 0=b0, 1=b1, 2=b2, 3=a1, 4=a2. Each section computes H(z) = (b0 + b1 z^-1 + b2 z^-2) / (1 + a1 z^-1 + a2 z^-2). Writes with term code 5 to 7 or with section 5 or above change nothing.
- R3: Each section runs transposed direct-form II with 48-bit state and signal values carrying 20 fraction bits:
  - y = b0*x + s1
  - s1' = b1*x - a1*y + s2
  - s2' = b2*x - a2*y

  Every product is floored to 20 fraction bits. Sections run in order 0 upward, and each section's y is the next section's x.
- R4: The section count `n_sections` is captured with the sample. A value of 0 acts as 1, and values above 5 act as 5. Sections beyond the count keep their state unchanged.
- R5: A sample accepted on a clock edge with N active sections produces a one-cycle `out_valid` pulse exactly 5N+1 edges later. `busy` is high from the edge after acceptance until that pulse, and it is low while `out_valid` is high.
- R6: A sample strobe that arrives while `busy` is high is ignored: it starts no pass and produces no output.
- R7: A coefficient write while `busy` is high is ignored. The pass in progress and later passes use the old value.
- R8: The final value is rounded to an integer with halves going toward plus infinity. It is then limited to the range -32768 to +32767 instead of wrapping.
- R9: `ovf_flag` is set together with any output pulse whose value was limited. It then stays high until reset or `clr`.
- R10: `clr` zeros all section state, abandons any pass in progress without an output pulse, and lowers `ovf_flag`. The coefficients are kept.
- R11: `out_sample` holds its value between output pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of filter state and overflow flag |
| in_valid | input | 1 | One-cycle strobe marking a new input sample |
| in_sample | input | 16 | Signed input sample |
| n_sections | input | 3 | Number of active sections for the pass |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 6 | Coefficient address {section, term} |
| cfg_wdata | input | 32 | Coefficient value, signed, 20 fraction bits |
| busy | output | 1 | A pass is in progress |
| out_valid | output | 1 | One-cycle strobe marking a new output word |
| out_sample | output | 16 | Rounded, saturated signed output |
| ovf_flag | output | 1 | Sticky saturation indicator |

## Verification
Several properties are checked on every cycle:
- the output strobe lasts a single cycle, and `busy` is low while it is high;
- `busy` never lasts longer than the five-section pass length;
- an accepted strobe always raises `busy`;
- `out_sample` only moves with the strobe;
- the overflow flag rises only with a strobe carrying a limit value, and it stays up until cleared.

The numbers themselves can only be shown by the bench's scenarios, which compare each output against a fixed-point model of the cascade. These scenarios cover:
- pure gain and rounding at half values;
- saturation at both limits;
- a three-section cascade with feedback over a sample sequence;
- clamping of the section count;
- strobes and writes that arrive mid-pass;
- invalid coefficient addresses;
- a clear issued in the middle of a pass.

// File: rtl/iir_comp_pkg.sv
// Shared widths, encodings and types for the cascaded biquad filter.
// Assumes signal values and coefficients share the same fraction width.
package iir_comp_pkg;
    localparam int SAMP_W   = 16;                 // converter word width
    localparam int COEF_W   = 32;                 // coefficient width
    localparam int FRAC_W   = 20;                 // fraction bits of coefficients and signals
    localparam int ACC_W    = 48;                 // state / signal width
    localparam int MAX_SECT = 5;                  // default section count
    localparam int TAPS     = 5;                  // terms per section
    localparam int SECT_AW  = 3;                  // section field of address
    localparam int TAP_AW   = 3;                  // term field of address
    localparam int CFG_AW   = SECT_AW + TAP_AW;
    localparam int PROD_W   = COEF_W + ACC_W;
    localparam int INT_W    = ACC_W - FRAC_W;     // integer bits after rounding
    localparam int STEP_W   = 3;

    localparam logic signed [COEF_W-1:0] COEF_UNITY = COEF_W'(1) << FRAC_W;
    localparam logic signed [ACC_W-1:0]  ROUND_HALF = ACC_W'(1) << (FRAC_W - 1);

    // Term codes inside a section (address low field)
    typedef enum logic [TAP_AW-1:0] {
        TERM_B0 = 3'd0,
        TERM_B1 = 3'd1,
        TERM_B2 = 3'd2,
        TERM_A1 = 3'd3,
        TERM_A2 = 3'd4
    } term_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_DONE = 2'd2
    } eng_state_e;
endpackage

// File: rtl/iir_coef_bank.sv
// Coefficient store: one register per term per section, written through a
// gated port and read by the engine through a single select.
// Assumes the engine only selects section indices below N_SECT.
module iir_coef_bank
    import iir_comp_pkg::*;
#(
    parameter int N_SECT = MAX_SECT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_allow,
    input  logic [CFG_AW-1:0]        wr_addr,
    input  logic [COEF_W-1:0]        wr_data,
    input  logic [SECT_AW-1:0]       rd_sect,
    input  logic [TAP_AW-1:0]        rd_term,
    output logic signed [COEF_W-1:0] rd_coef
);
    logic [TAPS-1:0][COEF_W-1:0] sect_bus [N_SECT];

    logic [SECT_AW-1:0] wr_sect;
    logic [TAP_AW-1:0]  wr_term;
    assign wr_sect = wr_addr[CFG_AW-1:TAP_AW];
    assign wr_term = wr_addr[TAP_AW-1:0];

    for (genvar s = 0; s < N_SECT; s++) begin : g_sect
        logic [TAPS-1:0][COEF_W-1:0] terms_q;

        // Hold this section's terms; reset to a unity pass-through.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int t = 0; t < TAPS; t++)
                    terms_q[t] <= (t == 0) ? COEF_UNITY : '0;
            end else if (wr_en && wr_allow && wr_sect == SECT_AW'(s)) begin
                for (int t = 0; t < TAPS; t++)
                    if (wr_term == TAP_AW'(t))
                        terms_q[t] <= wr_data;
            end
        end

        assign sect_bus[s] = terms_q;
    end

    // Select the term the engine asks for.
    always_comb begin
        rd_coef = '0;
        for (int s = 0; s < N_SECT; s++)
            for (int t = 0; t < TAPS; t++)
                if (rd_sect == SECT_AW'(s) && rd_term == TAP_AW'(t))
                    rd_coef = $signed(sect_bus[s][t]);
    end
endmodule

// File: rtl/iir_biquad_engine.sv
// Time-shared biquad engine: one multiplier, five products per section,
// transposed direct-form II, sections run in ascending order.
// Assumes the loaded filter is stable; sums wrap at ACC_W bits.
module iir_biquad_engine
    import iir_comp_pkg::*;
#(
    parameter int N_SECT = MAX_SECT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     start,
    input  logic [SAMP_W-1:0]        sample_in,
    input  logic [SECT_AW-1:0]       n_eff,
    input  logic signed [COEF_W-1:0] coef,
    output logic [SECT_AW-1:0]       coef_sect,
    output logic [TAP_AW-1:0]        coef_term,
    output logic                     busy,
    output logic                     done,
    output logic signed [ACC_W-1:0]  y_final
);
    localparam int STEPS = TAPS;

    eng_state_e                st_q;
    logic [SECT_AW-1:0]        sect_q, last_q;
    logic [STEP_W-1:0]         step_q;
    logic signed [ACC_W-1:0]   x_q, y_q, acc_q;
    logic signed [ACC_W-1:0]   s1_q [N_SECT];
    logic signed [ACC_W-1:0]   s2_q [N_SECT];
    logic signed [ACC_W-1:0]   s1_cur, s2_cur, mul_b, prod_q;
    logic signed [PROD_W-1:0]  prod_full;

    // Map the step to the coefficient term it consumes.
    always_comb begin
        case (step_q)
            3'd0:    coef_term = TERM_B0;
            3'd1:    coef_term = TERM_B1;
            3'd2:    coef_term = TERM_A1;
            3'd3:    coef_term = TERM_B2;
            default: coef_term = TERM_A2;
        endcase
    end
    assign coef_sect = sect_q;

    // Pick the current section's state words.
    always_comb begin
        s1_cur = '0;
        s2_cur = '0;
        for (int i = 0; i < N_SECT; i++)
            if (sect_q == SECT_AW'(i)) begin
                s1_cur = s1_q[i];
                s2_cur = s2_q[i];
            end
    end

    // Shared multiplier; product floored back to FRAC_W fraction bits.
    always_comb begin
        mul_b     = (step_q == 3'd2 || step_q == 3'd4) ? y_q : x_q;
        prod_full = $signed({{(PROD_W-COEF_W){coef[COEF_W-1]}}, coef})
                  * $signed({{(PROD_W-ACC_W){mul_b[ACC_W-1]}}, mul_b});
        prod_q    = prod_full[FRAC_W+ACC_W-1:FRAC_W];
    end

    // Sequencer and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st_q   <= ENG_IDLE;
            sect_q <= '0;
            last_q <= '0;
            step_q <= '0;
            x_q    <= '0;
            y_q    <= '0;
            acc_q  <= '0;
            for (int i = 0; i < N_SECT; i++) begin
                s1_q[i] <= '0;
                s2_q[i] <= '0;
            end
        end else begin
            case (st_q)
                ENG_IDLE: begin
                    if (start) begin
                        x_q    <= {{(ACC_W-SAMP_W-FRAC_W){sample_in[SAMP_W-1]}},
                                   sample_in, {FRAC_W{1'b0}}};
                        sect_q <= '0;
                        step_q <= '0;
                        last_q <= n_eff - SECT_AW'(1);
                        st_q   <= ENG_RUN;
                    end
                end
                ENG_RUN: begin
                    step_q <= (step_q == STEP_W'(STEPS-1)) ? '0 : step_q + STEP_W'(1);
                    case (step_q)
                        3'd0: y_q   <= prod_q + s1_cur;
                        3'd1: acc_q <= prod_q + s2_cur;
                        3'd2: begin
                            for (int i = 0; i < N_SECT; i++)
                                if (sect_q == SECT_AW'(i)) s1_q[i] <= acc_q - prod_q;
                        end
                        3'd3: acc_q <= prod_q;
                        default: begin
                            for (int i = 0; i < N_SECT; i++)
                                if (sect_q == SECT_AW'(i)) s2_q[i] <= acc_q - prod_q;
                            x_q <= y_q;
                            if (sect_q == last_q) st_q <= ENG_DONE;
                            else                  sect_q <= sect_q + SECT_AW'(1);
                        end
                    endcase
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    assign busy    = (st_q != ENG_IDLE);
    assign done    = (st_q == ENG_DONE);
    assign y_final = y_q;
endmodule

// File: rtl/iir_out_sat.sv
// Output stage: rounds a FRAC_W-fraction value half toward plus infinity
// and limits it to the converter word range. Purely combinational.
module iir_out_sat
    import iir_comp_pkg::*;
(
    input  logic signed [ACC_W-1:0]  y_in,
    output logic signed [SAMP_W-1:0] q_out,
    output logic                     sat
);
    logic signed [ACC_W-1:0] rounded;
    logic signed [INT_W-1:0] int_part;
    logic                    hi, lo;

    // Round, then compare the upper integer bits against the word's sign.
    always_comb begin
        rounded  = y_in + ROUND_HALF;
        int_part = rounded[ACC_W-1:FRAC_W];
        hi = !int_part[INT_W-1] && (|int_part[INT_W-2:SAMP_W-1]);
        lo =  int_part[INT_W-1] && !(&int_part[INT_W-2:SAMP_W-1]);
        if (hi)      q_out = {1'b0, {(SAMP_W-1){1'b1}}};
        else if (lo) q_out = {1'b1, {(SAMP_W-1){1'b0}}};
        else         q_out = int_part[SAMP_W-1:0];
        sat = hi || lo;
    end
endmodule

// File: rtl/iir_comp_filter.sv
// Top: cascaded biquad compensation filter. Clamps the section count,
// gates coefficient writes to idle time, and registers the saturated
// output with a one-cycle strobe and a sticky overflow flag.
// Assumes in_valid is a one-cycle strobe at the sample rate.
module iir_comp_filter
    import iir_comp_pkg::*;
#(
    parameter int N_SECT = MAX_SECT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [SAMP_W-1:0] in_sample,
    input  logic [SECT_AW-1:0] n_sections,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [COEF_W-1:0] cfg_wdata,
    output logic              busy,
    output logic              out_valid,
    output logic [SAMP_W-1:0] out_sample,
    output logic              ovf_flag
);
    logic [SECT_AW-1:0]        n_eff, rd_sect;
    logic [TAP_AW-1:0]         rd_term;
    logic signed [COEF_W-1:0]  rd_coef;
    logic                      eng_busy, eng_done, sat;
    logic signed [ACC_W-1:0]   y_final;
    logic signed [SAMP_W-1:0]  q_word;

    // Clamp the requested section count into 1..N_SECT.
    always_comb begin
        if (n_sections == '0)                    n_eff = SECT_AW'(1);
        else if (n_sections > SECT_AW'(N_SECT))  n_eff = SECT_AW'(N_SECT);
        else                                     n_eff = n_sections;
    end

    iir_coef_bank #(.N_SECT(N_SECT)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_allow (!eng_busy),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .rd_sect  (rd_sect),
        .rd_term  (rd_term),
        .rd_coef  (rd_coef)
    );

    iir_biquad_engine #(.N_SECT(N_SECT)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .start     (in_valid),
        .sample_in (in_sample),
        .n_eff     (n_eff),
        .coef      (rd_coef),
        .coef_sect (rd_sect),
        .coef_term (rd_term),
        .busy      (eng_busy),
        .done      (eng_done),
        .y_final   (y_final)
    );

    iir_out_sat u_sat (
        .y_in  (y_final),
        .q_out (q_word),
        .sat   (sat)
    );

    // Register the output word, its strobe and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sample <= '0;
            out_valid  <= 1'b0;
            ovf_flag   <= 1'b0;
        end else begin
            out_valid <= eng_done && !clr;
            if (clr) begin
                ovf_flag <= 1'b0;
            end else if (eng_done) begin
                out_sample <= q_word;
                if (sat) ovf_flag <= 1'b1;
            end
        end
    end

    assign busy = eng_busy;
endmodule

// File: rtl/iir_comp_filter_chk.sv
// Checker for iir_comp_filter: cycle-level protocol properties on the ports.
// Bound into every instance of the top module.
module iir_comp_filter_chk
    import iir_comp_pkg::*;
#(
    parameter int N_SECT = MAX_SECT
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              in_valid,
    input logic              busy,
    input logic              out_valid,
    input logic [SAMP_W-1:0] out_sample,
    input logic              ovf_flag
);
    localparam int BUSY_MAX = TAPS * N_SECT + 1;
    localparam int CNT_W    = $clog2(BUSY_MAX + 2);

    logic [CNT_W-1:0] busy_cnt;

    // Count consecutive busy cycles for the pass-length bound.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + CNT_W'(1);
        else           busy_cnt <= '0;
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R5
    AST_VALID_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !busy); // R5
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < CNT_W'(BUSY_MAX))); // R5
    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy && !clr) |=> busy); // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_sample)); // R11
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr) |=> ovf_flag); // R9
    AST_OVF_WITH_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> out_valid); // R9
    AST_OVF_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (out_sample == 16'h7FFF || out_sample == 16'h8000)); // R8
    AST_CLR_DROPS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!ovf_flag && !out_valid && !busy)); // R10
endmodule

bind iir_comp_filter iir_comp_filter_chk #(.N_SECT(N_SECT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .in_valid   (in_valid),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .ovf_flag   (ovf_flag)
);

// File: tb/iir_comp_filter_test.sv
// Directed bench for iir_comp_filter with a fixed-point model of the cascade.
module iir_comp_filter_test;
    localparam int CLK_PERIOD = 25;
    localparam int NS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic [2:0]  n_sections = 3'd1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        busy, out_valid, ovf_flag;
    logic [15:0] out_sample;

    int n_checks = 0;
    int n_fail   = 0;

    logic signed [31:0] cm  [NS][5];
    logic signed [47:0] s1m [NS];
    logic signed [47:0] s2m [NS];
    logic               model_ovf;

    iir_comp_filter uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_sample(in_sample), .n_sections(n_sections), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .busy(busy),
        .out_valid(out_valid), .out_sample(out_sample), .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        summary();
        $finish;
    end

    task automatic chk(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic signed [47:0] mq(logic signed [31:0] c, logic signed [47:0] v);
        logic signed [79:0] p;
        p = $signed({{48{c[31]}}, c}) * $signed({{32{v[47]}}, v});
        return p[67:20];
    endfunction

    function automatic int clampn(int n);
        if (n == 0) return 1;
        if (n > NS) return NS;
        return n;
    endfunction

    // Model one pass: cascade per the transposed form, then round and limit.
    function automatic longint model_pass(int x, int n);
        logic signed [47:0] xv, y, r;
        longint ip;
        xv = 48'(longint'(x)) <<< 20;
        y  = xv;
        for (int k = 0; k < clampn(n); k++) begin
            logic signed [47:0] t1;
            y      = mq(cm[k][0], xv) + s1m[k];
            t1     = mq(cm[k][1], xv) + s2m[k];
            s1m[k] = t1 - mq(cm[k][3], y);
            s2m[k] = mq(cm[k][2], xv) - mq(cm[k][4], y);
            xv     = y;
        end
        r  = y + 48'sd524288;
        ip = longint'(r >>> 20);
        if (ip > 32767)  begin model_ovf = 1'b1; return 32767;  end
        if (ip < -32768) begin model_ovf = 1'b1; return -32768; end
        return ip;
    endfunction

    function automatic void model_clear();
        for (int k = 0; k < NS; k++) begin
            s1m[k] = '0;
            s2m[k] = '0;
        end
        model_ovf = 1'b0;
    endfunction

    task automatic wr_coef(int s, int t, logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'((s << 3) | t); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (s < NS && t < 5) cm[s][t] = v;
    endtask

    task automatic run_sample(int x, int n, output longint got, output int lat);
        @(negedge clk);
        in_valid = 1'b1; in_sample = 16'(x); n_sections = 3'(n);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 999; got = 0;
        for (int c = 1; c <= 400; c++) begin
            @(negedge clk);
            if (out_valid) begin
                lat = c; got = longint'($signed(out_sample));
                break;
            end
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        model_clear();
    endtask

    task automatic t_reset();
        longint g; int l;
        chk("R1 out_sample after reset", longint'(out_sample), 0);
        chk("R1 out_valid after reset", longint'(out_valid), 0);
        chk("R1 busy after reset", longint'(busy), 0);
        chk("R1 ovf after reset", longint'(ovf_flag), 0);
        run_sample(1234, 5, g, l);
        chk("R1 pass-through value", g, model_pass(1234, 5));
        chk("R5 latency five sections", l, 26);
        chk("R5 busy low after pulse", longint'(busy), 0);
    endtask

    task automatic t_gain();
        longint g; int l;
        wr_coef(0, 0, 32'(627) << 20);
        run_sample(10, 1, g, l);
        chk("R2 b0 gain 627", g, 6270);
        chk("R5 latency one section", l, 6);
        run_sample(-52, 1, g, l);
        chk("R3 negative gain", g, -32604);
    endtask

    task automatic t_round();
        longint g; int l;
        wr_coef(0, 0, 32'h0008_0000);
        run_sample(3, 1, g, l);
        chk("R8 round +1.5", g, 2);
        run_sample(-3, 1, g, l);
        chk("R8 round -1.5", g, -1);
        run_sample(5, 1, g, l);
        chk("R8 round +2.5", g, 3);
        chk("R9 no overflow yet", longint'(ovf_flag), 0);
    endtask

    task automatic t_sat();
        longint g; int l;
        wr_coef(0, 0, 32'(627) << 20);
        run_sample(1000, 1, g, l);
        chk("R8 positive limit", g, 32767);
        chk("R9 flag set", longint'(ovf_flag), 1);
        run_sample(-1000, 1, g, l);
        chk("R8 negative limit", g, -32768);
        run_sample(10, 1, g, l);
        chk("R9 in-range value", g, 6270);
        chk("R9 flag sticky", longint'(ovf_flag), 1);
        pulse_clr();
        chk("R10 clr drops flag", longint'(ovf_flag), 0);
    endtask

    task automatic t_cascade();
        longint g; int l;
        int seq [8] = '{1000, 0, 0, 0, -700, 300, 300, 300};
        wr_coef(0, 0, 32'h0010_0000);
        wr_coef(0, 3, 32'hFFF8_0000);
        wr_coef(1, 0, 32'h0020_0000);
        wr_coef(1, 1, 32'hFFF0_0000);
        wr_coef(1, 2, 32'h0004_0000);
        wr_coef(1, 3, 32'h0004_0000);
        wr_coef(1, 4, 32'h0002_0000);
        wr_coef(2, 1, 32'h0000_0069);
        wr_coef(2, 3, 32'h0000_0069);
        pulse_clr();
        foreach (seq[i]) begin
            run_sample(seq[i], 3, g, l);
            chk("R3 cascade sequence", g, model_pass(seq[i], 3));
            chk("R5 latency three sections", l, 16);
        end
        run_sample(400, 0, g, l);
        chk("R4 count 0 acts as 1 value", g, model_pass(400, 0));
        chk("R4 count 0 latency", l, 6);
        run_sample(-250, 7, g, l);
        chk("R4 count 7 acts as 5 value", g, model_pass(-250, 7));
        chk("R4 count 7 latency", l, 26);
    endtask

    task automatic t_busy_ignore();
        int pulses = 0;
        longint g = 0;
        longint e;
        @(negedge clk);
        in_valid = 1'b1; in_sample = 16'(900); n_sections = 3'd5;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R6 busy during pass", longint'(busy), 1);
        in_valid = 1'b1; in_sample = 16'(-5000);
        cfg_we = 1'b1; cfg_addr = 6'h00; cfg_wdata = 32'h0030_0000;
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (out_valid) begin pulses++; g = longint'($signed(out_sample)); end
        end
        e = model_pass(900, 5);
        chk("R6 single output pulse", pulses, 1);
        chk("R6 value of first sample only", g, e);
        begin
            int l;
            run_sample(120, 5, g, l);
            chk("R7 write during pass ignored", g, model_pass(120, 5));
        end
    endtask

    task automatic t_bad_addr();
        longint g; int l;
        wr_coef(0, 6, 32'h0123_4567);
        wr_coef(6, 0, 32'h0765_4321);
        run_sample(-321, 3, g, l);
        chk("R2 invalid addresses ignored", g, model_pass(-321, 3));
    endtask

    task automatic t_clear();
        int pulses = 0;
        longint g; int l;
        @(negedge clk);
        in_valid = 1'b1; in_sample = 16'(2000); n_sections = 3'd5;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_clear();
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (out_valid) pulses++;
        end
        chk("R10 abandoned pass no pulse", pulses, 0);
        chk("R10 busy low after clr", longint'(busy), 0);
        run_sample(0, 3, g, l);
        chk("R10 state zeroed", g, 0);
        run_sample(500, 3, g, l);
        chk("R10 coefficients kept", g, model_pass(500, 3));
    endtask

    task automatic t_hold();
        longint held;
        int moved = 0;
        held = longint'($signed(out_sample));
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (longint'($signed(out_sample)) != held || out_valid) moved++;
        end
        chk("R11 output held between pulses", moved, 0);
    endtask

    initial begin
        for (int s = 0; s < NS; s++)
            for (int t = 0; t < 5; t++)
                cm[s][t] = (t == 0) ? 32'h0010_0000 : 32'h0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gain();
        t_round();
        t_sat();
        t_cascade();
        t_busy_ignore();
        t_bad_addr();
        t_clear();
        t_hold();
        summary();
        $finish;
    end
endmodule